// File: doc/BRIEF.md
# Stable Marked-Element Packer

The block accepts an array of N data words, each paired with a one-bit flag, and returns the same words in a new order. Flagged words move to the low slots and unflagged words fill the high slots. Inside each group, words keep the order they had on input. The block also returns how many words were flagged.

Each word's destination slot comes from two running counts, one over the flags and one over their complements. Both counts are built in a logarithmic number of doubling steps, one step per clock. Every flagged word goes to its flagged-count position. Every unflagged word goes to the total flagged count plus its unflagged-count position. Both positions are shifted down by one because slots are numbered from zero. A final step copies each word to its slot in a single cycle.

The array goes in and comes out as whole-array transfers on valid/ready handshakes. `in_ready` is high only while the block is idle. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. The result is offered with `out_valid` and stays frozen until the consumer raises `out_ready`, which applies back-pressure for as long as it is low. `in_ready` returns on the cycle after the result has been taken.

Top module: `stbpk_top`

## Requirements
- R1: `in_ready` is high exactly when the block is idle and is never high together with `out_valid`. Data and flags are captured on the accepting edge. Changes on `in_data` or `in_mark` after that edge have no effect on the result.
- R2: Output slots 0 to m-1, where m is the number of flagged inputs, hold the flagged words in increasing order of their input index. Input word i occupies bits [i*W +: W], and slot j of the output occupies bits [j*W +: W].
- R3: Output slots m to N-1 hold the unflagged words in increasing order of their input index.
- R4: `out_count` equals the number of bits set in the captured `in_mark`, and it is never above N.
- R5: When no flag is set, or when all flags are set, the output array equals the input array. With all flags set, `out_count` equals N.
- R6: `out_valid` first reads high after the (clog2(N)+1)-th rising edge that follows the accepting edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_count` hold their values.
- R8: `done` is high for exactly one cycle per result: the first cycle in which `out_valid` is high.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R10: After an edge where `out_valid` and `out_ready` are both high, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input array offered |
| in_ready | output | 1 | Block is idle and can take an array |
| in_data | input | N*W | Input words, word i at [i*W +: W] |
| in_mark | input | N | Flag per input word, bit i for word i |
| out_valid | output | 1 | Packed result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N*W | Packed words, slot j at [j*W +: W] |
| out_count | output | clog2(N+1) | Number of flagged words |
| done | output | 1 | One-cycle pulse when a result appears |

## Verification
The bench drives empty and full flag sets, where an off-by-one error in the destination offset would shift every word or drop slot 0. It also uses a lone flag at the first or last index, which exposes a scan that stops one doubling step short or mixes up the group base. Alternating flag patterns and random patterns check that the order inside each group is kept, which a swap-based partition would break. The bench overwrites the inputs after acceptance and holds `out_ready` low for varying times. A block that reads its inputs live would then produce wrong data, and a block that drops its result under back-pressure or repeats `done` would be caught. Latency is counted edge by edge, so a missing or extra scan step shows up.

// File: rtl/stbpk_pkg.sv
package stbpk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_SCATTER = 2'd2,
    ST_HOLD    = 2'd3
  } stbpk_state_e;
endpackage

// File: rtl/stbpk_ctrl.sv
module stbpk_ctrl
  import stbpk_pkg::*;
#(
  parameter int N = 8,
  localparam int LOG2N = $clog2(N),
  localparam int STW = $clog2(LOG2N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           out_ready,
  output logic           in_ready,
  output logic           load,
  output logic           step,
  output logic           scatter,
  output logic           out_valid,
  output logic           done,
  output logic [STW-1:0] stage
);
  stbpk_state_e state_q;
  logic [STW-1:0] stage_q;
  logic done_q;

  localparam logic [STW-1:0] LAST_STAGE = STW'(LOG2N - 1);

  assign in_ready  = (state_q == ST_IDLE);
  assign load      = in_valid && (state_q == ST_IDLE);
  assign step      = (state_q == ST_SCAN);
  assign scatter   = (state_q == ST_SCATTER);
  assign out_valid = (state_q == ST_HOLD);
  assign done      = done_q;
  assign stage     = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_SCATTER);
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            state_q <= ST_SCAN;
            stage_q <= '0;
          end
        end
        ST_SCAN: begin
          if (stage_q == LAST_STAGE) state_q <= ST_SCATTER;
          else stage_q <= stage_q + 1'b1;
        end
        ST_SCATTER: state_q <= ST_HOLD;
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R8
  done_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
  // R6
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (stage <= LAST_STAGE));
endmodule

// File: rtl/stbpk_scan.sv
module stbpk_scan #(
  parameter int N = 8,
  localparam int LOG2N = $clog2(N),
  localparam int STW = $clog2(LOG2N + 1),
  localparam int CW = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [N-1:0]          load_flags,
  input  logic                  step,
  input  logic [STW-1:0]        stage,
  output logic [N-1:0][CW-1:0]  cnt
);
  logic [N-1:0][CW-1:0] cnt_q;
  logic [N-1:0][CW-1:0] addend;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      addend[i] = '0;
      for (int s = 0; s < LOG2N; s++) begin
        if (stage == STW'(s) && i >= (1 << s)) begin
          addend[i] = cnt_q[(i >= (1 << s)) ? (i - (1 << s)) : 0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= CW'(load_flags[i]);
    end else if (step) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= cnt_q[i] + addend[i];
    end
  end

  assign cnt = cnt_q;

  // R4
  head_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(cnt[0]));
  // R4
  tail_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt[N-1] >= $past(cnt[N-1])));
endmodule

// File: rtl/stbpk_scatter.sv
module stbpk_scatter #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0][W-1:0]  src,
  input  logic [N-1:0]         flag,
  input  logic [N-1:0][CW-1:0] cnt_set,
  input  logic [N-1:0][CW-1:0] cnt_clr,
  output logic [N-1:0][W-1:0]  dst,
  output logic [N-1:0][N-1:0]  sel
);
  logic [N-1:0][CW-1:0] slot;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (flag[i]) slot[i] = cnt_set[i] - 1'b1;
      else         slot[i] = cnt_set[N-1] + cnt_clr[i] - 1'b1;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_slot
    always_comb begin
      dst[j] = '0;
      for (int i = 0; i < N; i++) begin
        sel[j][i] = (slot[i] == CW'(j));
        if (sel[j][i]) dst[j] = dst[j] | src[i];
      end
    end
  end
endmodule

// File: rtl/stbpk_top.sv
module stbpk_top #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LOG2N = $clog2(N),
  localparam int STW = $clog2(LOG2N + 1),
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_data,
  input  logic [N-1:0]   in_mark,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*W-1:0] out_data,
  output logic [CW-1:0]  out_count,
  output logic           done
);
  logic load, step, scatter;
  logic [STW-1:0] stage;
  logic [N-1:0][W-1:0]  data_q;
  logic [N-1:0]         mark_q;
  logic [N-1:0][CW-1:0] cnt_set, cnt_clr;
  logic [N-1:0][W-1:0]  packed_w;
  logic [N-1:0][N-1:0]  sel;
  logic [N-1:0][W-1:0]  res_q;
  logic [CW-1:0]        count_q;

  stbpk_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .load(load), .step(step), .scatter(scatter),
    .out_valid(out_valid), .done(done), .stage(stage)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= '0;
    end else if (load) begin
      data_q <= in_data;
      mark_q <= in_mark;
    end
  end

  stbpk_scan #(.N(N)) u_scan_set (
    .clk(clk), .rst_n(rst_n), .load(load), .load_flags(in_mark),
    .step(step), .stage(stage), .cnt(cnt_set)
  );

  stbpk_scan #(.N(N)) u_scan_clr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_flags(~in_mark),
    .step(step), .stage(stage), .cnt(cnt_clr)
  );

  stbpk_scatter #(.N(N), .W(W)) u_scatter (
    .src(data_q), .flag(mark_q), .cnt_set(cnt_set), .cnt_clr(cnt_clr),
    .dst(packed_w), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      count_q <= '0;
    end else if (scatter) begin
      res_q   <= packed_w;
      count_q <= cnt_set[N-1];
    end
  end

  assign out_data  = res_q;
  assign out_count = count_q;

  // R2
  counts_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scatter |-> (32'(cnt_set[N-1]) + 32'(cnt_clr[N-1]) == N));
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_count) <= N));
  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_count)));
  // R1
  inputs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(data_q) && $stable(mark_q)));

  for (genvar j = 0; j < N; j++) begin : g_cov
    // R3
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scatter |-> $onehot(sel[j]));
  end
endmodule

// File: tb/stbpk_top_tb.sv
`timescale 1ns/1ps
module stbpk_top_tb;
  localparam int N = 8;
  localparam int W = 8;
  localparam int CW = $clog2(N + 1);
  localparam int LAT = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0] in_mark = '0;
  logic in_ready, out_valid, done;
  logic [N*W-1:0] out_data;
  logic [CW-1:0] out_count;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stbpk_top #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_count(out_count),
    .done(done)
  );

  function automatic logic [N*W-1:0] pack_ref(logic [N*W-1:0] d, logic [N-1:0] m);
    logic [N*W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
    for (int i = 0; i < N; i++)
      if (!m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
    return r;
  endfunction

  function automatic int ones(logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act,
                     input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [N*W-1:0] d, input logic [N-1:0] m,
                     input int stall, input string tag);
    logic [N*W-1:0] exp = pack_ref(d, m);
    logic [N*W-1:0] front_mask = '0;
    int mc = ones(m);
    int lat = 0;
    logic [N*W-1:0] held;
    for (int j = 0; j < mc; j++) front_mask[j*W +: W] = '1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mark = m;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = {$urandom, $urandom};
    in_mark = N'($urandom);
    while (!out_valid && lat < 50) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    // R6 latency
    chk(lat == LAT, "R6 latency", N*W'(lat), N*W'(LAT));
    // R8 done on first valid cycle
    chk(done == 1'b1, "R8 done pulse", N*W'(done), N*W'(1));
    // R4 count
    chk(int'(out_count) == mc, "R4 count", N*W'(out_count), N*W'(mc));
    // R2 front group (R1: inputs overwritten after accept)
    chk((out_data & front_mask) == (exp & front_mask), {"R2 front ", tag},
        out_data & front_mask, exp & front_mask);
    // R3 back group
    chk((out_data & ~front_mask) == (exp & ~front_mask), {"R3 back ", tag},
        out_data & ~front_mask, exp & ~front_mask);
    held = out_data;
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); @(negedge clk);
      // R7 hold under back-pressure
      chk(out_valid && out_data == held, "R7 hold", out_data, held);
      // R8 single pulse
      chk(done == 1'b0, "R8 done low", N*W'(done), '0);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    // R10 release; R1 ready back when idle
    chk(!out_valid && in_ready, "R10 release", N*W'({out_valid, in_ready}), N*W'(2'b01));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready && !out_valid && !done, "R9 reset",
        N*W'({in_ready, out_valid, done}), N*W'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !done, "R9 after reset",
        N*W'({in_ready, out_valid, done}), N*W'(3'b100));
    begin
      logic [N*W-1:0] d = 64'h8877_6655_4433_2211;
      run(d, 8'h00, 1, "R5 none");
      chk(pack_ref(d, 8'h00) == d, "R5 identity ref", pack_ref(d, 8'h00), d);
      run(d, 8'hFF, 0, "R5 all");
      run(d, 8'h80, 2, "last only");
      run(d, 8'h01, 0, "first only");
      run(d, 8'h55, 3, "alternate");
      run(d, 8'hAA, 1, "alternate2");
    end
    for (int t = 0; t < 40; t++) begin
      run({$urandom, $urandom}, N'($urandom), int'($urandom % 4), "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule